// File: doc/BRIEF.md
# Embedded Operation Status Readback

This block forms the byte returned on a read from a memory array whose program or erase job runs on its own. While such a job runs, a read does not return array contents. It returns a status byte instead. The top bit is a polling bit: it shows the inverse of the top bit of the byte being programmed, or 0 for any erase job. The bit below it is a toggle bit that changes value on every read. When no job is running, reads pass the array data through unchanged.

A surrounding sequencer decides when a job is running and drives the block with a start event and a done event. The start event is raised on the write strobe from which status becomes valid: the fourth strobe of a program command, the sixth of a chip erase, or the last sector erase strobe, which opens the sector timeout window. Together with the start event, the sequencer supplies the job type and the byte last written. The block captures both, and it registers the read result one cycle after each read strobe.

Top module: `opstat_readback`

## Requirements
- R1: After reset, `rd_data` is 0x00 and no job is active.
- R2: While no job is active, the cycle after `rd_strobe` gives `rd_data` equal to the `array_data` that was present with the strobe.
- R3: While a job of type program (`op_kind` = 0) is active, bit 7 of a read result is the inverse of bit 7 of the `wr_byte` captured at `op_start`.
- R4: While a job of type chip erase (1), sector timeout window (2) or sector erase (3) is active, bit 7 of a read result is 0.
- R5: Bit 6 of a read result taken during a job is a toggle bit. The toggle is cleared by `op_start`, so the first read of a job returns 0. Every later read in the same job returns the inverse of the read before it.
- R6: During a job, bits 5 to 0 of a read result equal bits 5 to 0 of the byte captured at `op_start`.
- R7: After `op_done`, reads return plain array data again, including the true bit 7.
- R8: `rd_data` holds its value in every cycle without `rd_strobe`.
- R9: A read in the same cycle as `op_done` still returns the status byte. A read in the same cycle as `op_start` from idle returns array data, and the toggle still starts the new job at 0.
- R10: An `op_start` while a job is active loads the new type and byte and clears the toggle, for example when the sector timeout window gives way to the sector erase itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_start | input | 1 | Job becomes active; captures type and byte |
| op_done | input | 1 | Job has completed |
| op_kind | input | 2 | Job type: 0 program, 1 chip erase, 2 sector timeout window, 3 sector erase |
| wr_byte | input | 8 | Byte last written by the command |
| rd_strobe | input | 1 | Read request, one cycle |
| array_data | input | 8 | Data read from the array |
| rd_data | output | 8 | Registered read result |

## Verification
Two pairs of events can fall in the same clock cycle. A read can coincide with job completion, and a read can coincide with job start. The bench drives each pair in a single cycle. It expects the status byte when the read meets completion, and array data when the read meets a start from idle. On the read that follows the start, it expects the toggle to come back as 0. A start raised while a job is already active is also checked, to confirm that the toggle restarts.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

    localparam int DATA_W   = 8;
    localparam int POLL_POS = DATA_W - 1;
    localparam int TGL_POS  = DATA_W - 2;
    localparam int KIND_W   = 2;

    typedef enum logic [KIND_W-1:0] {
        OP_PROGRAM    = 2'd0,
        OP_CHIP_ERASE = 2'd1,
        OP_SECT_WAIT  = 2'd2,
        OP_SECT_ERASE = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic              busy;
        op_kind_e          kind;
        logic [DATA_W-1:0] data;
    } op_state_t;

    localparam op_state_t OP_STATE_IDLE = '{busy: 1'b0, kind: OP_PROGRAM, data: '0};

    // Status byte shown while a job runs.
    function automatic logic [DATA_W-1:0] compose_status(input op_state_t st, input logic tgl);
        logic [DATA_W-1:0] res;
        res           = st.data;
        res[POLL_POS] = (st.kind == OP_PROGRAM) ? ~st.data[POLL_POS] : 1'b0;
        res[TGL_POS]  = tgl;
        return res;
    endfunction

endpackage

// File: rtl/opstat_tracker.sv
module opstat_tracker
    import opstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_start,
    input  logic              op_done,
    input  op_kind_e          kind_in,
    input  logic [DATA_W-1:0] byte_in,
    output op_state_t         state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OP_STATE_IDLE;
        end else if (op_start) begin
            state.busy <= 1'b1;
            state.kind <= kind_in;
            state.data <= byte_in;
        end else if (op_done) begin
            state.busy <= 1'b0;
        end
    end

endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    output logic tgl
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tgl <= 1'b0;
        end else if (advance) begin
            tgl <= ~tgl;
        end
    end

endmodule

// File: rtl/opstat_outreg.sv
module opstat_outreg
    import opstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_strobe,
    input  op_state_t         state,
    input  logic              tgl,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] next_val;

    always_comb begin
        next_val = state.busy ? compose_status(state, tgl) : array_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_strobe) begin
            rd_data <= next_val;
        end
    end

endmodule

// File: rtl/opstat_readback.sv
module opstat_readback
    import opstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_start,
    input  logic              op_done,
    input  logic [KIND_W-1:0] op_kind,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);

    op_state_t state;
    logic      tgl;
    logic      tgl_adv;

    assign tgl_adv = rd_strobe & state.busy;

    opstat_tracker u_tracker (
        .clk      (clk),
        .rst      (rst),
        .op_start (op_start),
        .op_done  (op_done),
        .kind_in  (op_kind_e'(op_kind)),
        .byte_in  (wr_byte),
        .state    (state)
    );

    opstat_toggle u_toggle (
        .clk     (clk),
        .rst     (rst),
        .clear   (op_start),
        .advance (tgl_adv),
        .tgl     (tgl)
    );

    opstat_outreg u_outreg (
        .clk        (clk),
        .rst        (rst),
        .rd_strobe  (rd_strobe),
        .state      (state),
        .tgl        (tgl),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/opstat_readback_chk.sv
module opstat_readback_chk
    import opstat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_start,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data,
    input op_state_t         state,
    input logic              tgl
);

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !state.busy) |=> rd_data == $past(array_data)); // R2

    AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && state.busy && state.kind == OP_PROGRAM)
        |=> rd_data[POLL_POS] == ~$past(state.data[POLL_POS])); // R3

    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && state.busy && state.kind != OP_PROGRAM)
        |=> rd_data[POLL_POS] == 1'b0); // R4

    AST_TGL_START: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !tgl); // R5

    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && state.busy && !op_start) |=> tgl != $past(tgl)); // R5

    AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && state.busy)
        |=> rd_data[TGL_POS-1:0] == $past(state.data[TGL_POS-1:0])); // R6

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(rd_data)); // R8

endmodule

bind opstat_readback opstat_readback_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_start   (op_start),
    .rd_strobe  (rd_strobe),
    .array_data (array_data),
    .rd_data    (rd_data),
    .state      (state),
    .tgl        (tgl)
);

// File: tb/test_opstat_readback.sv
module test_opstat_readback;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_start = 1'b0;
    logic       op_done = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic [7:0] wr_byte = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] array_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    // Bench view of the requirements
    logic       m_busy = 1'b0;
    logic [1:0] m_kind = 2'd0;
    logic [7:0] m_byte = 8'h00;
    logic       m_tgl  = 1'b0;
    logic [7:0] last_exp = 8'h00;

    always #4 clk = ~clk;

    opstat_readback i_opstat_readback (
        .clk        (clk),
        .rst        (rst),
        .op_start   (op_start),
        .op_done    (op_done),
        .op_kind    (op_kind),
        .wr_byte    (wr_byte),
        .rd_strobe  (rd_strobe),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One driven cycle; strobes drop just after the capturing edge.
    task automatic step(input logic st, input logic dn, input logic rd,
                        input logic [1:0] k, input logic [7:0] b,
                        input logic [7:0] arr, input string tag);
        logic [7:0] e;
        @(negedge clk);
        op_start   = st;
        op_done    = dn;
        rd_strobe  = rd;
        op_kind    = k;
        wr_byte    = b;
        array_data = arr;
        if (rd) begin
            if (m_busy) begin
                e = m_byte;
                e[7] = (m_kind == 2'd0) ? ~m_byte[7] : 1'b0;
                e[6] = m_tgl;
            end else begin
                e = arr;
            end
            exp_q.push_back(e);
            tag_q.push_back(tag);
            last_exp = e;
        end
        if (st) begin
            m_busy = 1'b1;
            m_kind = k;
            m_byte = b;
            m_tgl  = 1'b0;
        end else begin
            if (rd && m_busy) m_tgl = ~m_tgl;
            if (dn) m_busy = 1'b0;
        end
        @(posedge clk);
        #1;
        op_start  = 1'b0;
        op_done   = 1'b0;
        rd_strobe = 1'b0;
    endtask

    task automatic rd(input logic [7:0] arr, input string tag);
        step(1'b0, 1'b0, 1'b1, 2'd0, 8'h00, arr, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h5A, "");
    endtask

    // Monitor: pops expected items as read results appear.
    always @(posedge clk) rd_seen <= rd_strobe;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL scoreboard: actual %02h expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset value", rd_data, 8'h00);
        rst = 1'b0;

        rd(8'hA5, "R2 idle pass");
        rd(8'h3C, "R2 idle pass second");
        idle(3);
        check("R8 hold without strobe", rd_data, last_exp);

        // Program, byte top bit 0
        step(1'b1, 1'b0, 1'b0, 2'd0, 8'h3C, 8'h11, "");
        rd(8'h11, "R3 R5 R6 program read 1");
        rd(8'h11, "R5 program read 2");
        idle(2);
        check("R8 hold in job", rd_data, last_exp);
        rd(8'h11, "R5 program read 3");
        step(1'b0, 1'b1, 1'b1, 2'd0, 8'h00, 8'h3C, "R9 read with done");
        rd(8'h3C, "R7 true data after program");

        // Program, byte top bit 1
        step(1'b1, 1'b0, 1'b0, 2'd0, 8'hC3, 8'h00, "");
        rd(8'h00, "R3 program inverted bit 7");
        step(1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 8'h00, "");
        rd(8'hC3, "R7 true data bit 7 set");

        // Chip erase
        step(1'b1, 1'b0, 1'b0, 2'd1, 8'hFF, 8'h00, "");
        rd(8'h00, "R4 chip erase poll 0");
        rd(8'h00, "R4 R5 chip erase read 2");
        step(1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 8'h00, "");
        rd(8'hFF, "R7 erased data");

        // Start and read in one cycle from idle
        step(1'b1, 1'b0, 1'b1, 2'd2, 8'hA7, 8'h69, "R9 read with start");
        rd(8'h00, "R9 R4 first read after start");
        rd(8'h00, "R4 timeout window read 2");
        // Timeout window gives way to sector erase
        step(1'b1, 1'b0, 1'b0, 2'd3, 8'h95, 8'h00, "");
        rd(8'h00, "R10 toggle restarts");
        rd(8'h00, "R10 R4 sector erase read 2");
        step(1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 8'h00, "");
        rd(8'hFF, "R7 after sector erase");

        idle(2);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule